// File: doc/BRIEF.md
# Address Former with Parallel 16-bit Incrementer

This block forms the 16-bit memory address of a small 8-bit processor from two independently steered byte buses. The low byte comes from the program counter low half, the data pointer low half, the stack pointer or a temporary byte. The high byte comes from the program counter high half, the data pointer high half or a fixed page value: zero page, stack page or vector page. Selecting the temporary byte as the low half lets an indirect access reach its target one cycle early.

The block owns the program counter and the stack pointer. A 16-bit incrementer sits beside the ALU. It takes the address now on the two byte buses and adds or subtracts one. Its result can be written back into the program counter, or its low byte into the stack pointer, in the same cycle. The ALU is never involved. A push puts the stack address out and decrements the pointer with one write-back strobe. A pull uses a separate increment strobe first and then reads at the new address. The block also provides the constant low bytes of the interrupt vectors, which the control loads into the data pointer. It provides the stack pointer's reset value as well.

Top module: `addr_gen`

## Requirements
- R1: While `rstN` is low and after its release, the stack pointer holds 0xFF and the program counter holds the RESET_PC parameter (default 0x0000). Each keeps that value until a load or write-back strobe arrives.
- R2: `lowSel` steers the low address byte: 0 gives the PC low byte, 1 `dpl`, 2 the stack pointer, 3 `tByte`.
- R3: `highSel` steers the high address byte: 0 gives the PC high byte, 1 `dph`, 2 the constant 0x00, 3 the constant 0x01, 4 the constant 0xFF. The reserved codes 5 to 7 give 0x00.
- R4: `incBus` equals `addr` plus one modulo 65536 when `incDir` is 0, and `addr` minus one modulo 65536 when `incDir` is 1. It is combinational, so it is valid in the same cycle.
- R5: With `wbPc` high and `pcLoad` low, the PC takes `incBus` at the clock edge. This includes the wrap from 0xFFFF to 0x0000.
- R6: With `wbSp` high and `spLoad` low, the stack pointer takes only the low byte of `incBus`, so it wraps inside page 0x01 (0x00 decremented gives 0xFF, 0xFF incremented gives 0x00). A push cycle shows the old stack address on `addr` while the pointer decrements at the edge.
- R7: `pcLoad` writes `pcLoadVal` and `spLoad` writes `spLoadVal` at the clock edge. A load wins over a write-back strobe in the same cycle.
- R8: `vecLow` gives 0xFA, 0xFC, 0xFE, 0xFF for `vecSel` 0, 1, 2, 3.
- R9: With no load or write-back strobe, the PC and SP keep their values, whatever the select and direction inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lowSel | input | 2 | Low address byte source code |
| highSel | input | 3 | High address byte source code |
| incDir | input | 1 | 0 increment, 1 decrement |
| wbPc | input | 1 | Write incrementer result into PC |
| wbSp | input | 1 | Write incrementer low byte into SP |
| pcLoad | input | 1 | Load PC from pcLoadVal |
| pcLoadVal | input | 16 | PC load value |
| spLoad | input | 1 | Load SP from spLoadVal |
| spLoadVal | input | 8 | SP load value |
| dpl | input | 8 | Data pointer low byte |
| dph | input | 8 | Data pointer high byte |
| tByte | input | 8 | Temporary byte usable as address low |
| vecSel | input | 2 | Vector low-byte constant select |
| addr | output | 16 | Memory address |
| incBus | output | 16 | Incrementer result |
| pcOut | output | 16 | Current program counter |
| spOut | output | 8 | Current stack pointer |
| vecLow | output | 8 | Vector low-byte constant |

## Verification
The hardest cases to reach are the wraps at the register edges: the PC rolling from 0xFFFF to 0x0000, and the stack pointer crossing 0x00/0xFF while the incrementer's high byte is dropped. Both need the register preloaded to a boundary value before the write-back cycle. The bench first uses the load ports to place the PC and SP at those values. It then issues a single write-back with the matching select codes. It also places a load and a write-back in the same cycle to show which one takes effect.

// File: rtl/addrgen_pkg.sv
package addrgen_pkg;
  typedef enum logic [1:0] {LO_PCL, LO_DPL, LO_SP, LO_T} loSrc_e;
  typedef enum logic [2:0] {
    HI_PCH, HI_DPH, HI_ZERO, HI_STACK, HI_VEC, HI_RSV5, HI_RSV6, HI_RSV7
  } hiSrc_e;

  typedef struct packed {
    logic   pcLd;
    logic   pcWb;
    logic   spLd;
    logic   spWb;
    logic   dec;
    loSrc_e loSel;
    hiSrc_e hiSel;
  } addrStrobes_t;
endpackage

// File: rtl/addr_inc.sv
module addr_inc #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] src,
  input  logic              dec,
  output logic [ADDR_W-1:0] res
);
  // one adder; decrement adds all-ones, wrapping modulo 2^ADDR_W
  logic [ADDR_W-1:0] delta;
  assign delta = dec ? {ADDR_W{1'b1}} : ADDR_W'(1);
  assign res   = src + delta;
endmodule

// File: rtl/addr_ctrl.sv
module addr_ctrl
  import addrgen_pkg::*;
(
  input  logic [1:0]   lowSel,
  input  logic [2:0]   highSel,
  input  logic         incDir,
  input  logic         wbPc,
  input  logic         wbSp,
  input  logic         pcLoad,
  input  logic         spLoad,
  output addrStrobes_t st
);
  // loads take precedence over incrementer write-back (R7)
  always_comb begin
    st.pcLd  = pcLoad;
    st.pcWb  = wbPc & ~pcLoad;
    st.spLd  = spLoad;
    st.spWb  = wbSp & ~spLoad;
    st.dec   = incDir;
    st.loSel = loSrc_e'(lowSel);
    st.hiSel = hiSrc_e'(highSel);
  end
endmodule

// File: rtl/addr_path.sv
module addr_path
  import addrgen_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 2 * BYTE_W,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  addrStrobes_t      st,
  input  logic [ADDR_W-1:0] pcLoadVal,
  input  logic [BYTE_W-1:0] spLoadVal,
  input  logic [BYTE_W-1:0] dpl,
  input  logic [BYTE_W-1:0] dph,
  input  logic [BYTE_W-1:0] tByte,
  input  logic [1:0]        vecSel,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] incBus,
  output logic [ADDR_W-1:0] pcOut,
  output logic [BYTE_W-1:0] spOut,
  output logic [BYTE_W-1:0] vecLow
);
  localparam logic [BYTE_W-1:0] ALL_ONES   = {BYTE_W{1'b1}};
  localparam logic [BYTE_W-1:0] PAGE_ZERO  = '0;
  localparam logic [BYTE_W-1:0] PAGE_STACK = BYTE_W'(1);
  localparam logic [BYTE_W-1:0] PAGE_VEC   = ALL_ONES;
  localparam logic [BYTE_W-1:0] SP_INIT    = ALL_ONES;

  logic [ADDR_W-1:0] pcReg;
  logic [BYTE_W-1:0] spReg;
  logic [BYTE_W-1:0] loBus, hiBus;
  logic              armed;

  // low address byte source
  always_comb begin
    unique case (st.loSel)
      LO_PCL:  loBus = pcReg[BYTE_W-1:0];
      LO_DPL:  loBus = dpl;
      LO_SP:   loBus = spReg;
      default: loBus = tByte;
    endcase
  end

  // high address byte source, fixed pages included
  always_comb begin
    case (st.hiSel)
      HI_PCH:   hiBus = pcReg[ADDR_W-1:BYTE_W];
      HI_DPH:   hiBus = dph;
      HI_STACK: hiBus = PAGE_STACK;
      HI_VEC:   hiBus = PAGE_VEC;
      default:  hiBus = PAGE_ZERO;
    endcase
  end

  assign addr = {hiBus, loBus};

  addr_inc #(.ADDR_W(ADDR_W)) inc_i (
    .src (addr),
    .dec (st.dec),
    .res (incBus)
  );

  // vector low-byte constants: all-ones minus 5, 3, 1, 0
  always_comb begin
    case (vecSel)
      2'd0:    vecLow = ALL_ONES - BYTE_W'(5);
      2'd1:    vecLow = ALL_ONES - BYTE_W'(3);
      2'd2:    vecLow = ALL_ONES - BYTE_W'(1);
      default: vecLow = ALL_ONES;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg <= RESET_PC;
      spReg <= SP_INIT;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (st.pcLd)      pcReg <= pcLoadVal;
      else if (st.pcWb) pcReg <= incBus;
      if (st.spLd)      spReg <= spLoadVal;
      else if (st.spWb) spReg <= incBus[BYTE_W-1:0];
    end
  end

  assign pcOut = pcReg;
  assign spOut = spReg;

  // R5: PC write-back lands the previous incrementer result
  p_pc_wb_r5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(st.pcWb)) |-> pcReg == $past(incBus));

  // R6: SP write-back keeps only the low byte of the previous result
  p_sp_wb_r6: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(st.spWb)) |-> spReg == $past(incBus[BYTE_W-1:0]));

  // R7: a load captures the presented value
  p_pc_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(st.pcLd)) |-> pcReg == $past(pcLoadVal));

  // R9: without strobes both registers hold
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(st.pcLd || st.pcWb || st.spLd || st.spWb))
      |-> ($stable(pcReg) && $stable(spReg)));

  // R4: incrementer result sits one step away from the address
  p_inc_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (incBus - addr == ADDR_W'(1)) || (addr - incBus == ADDR_W'(1)));

  // R8: vector constants stay in the top page slot
  always_comb begin
    a_vec_top_r8: assert (vecLow[BYTE_W-1:3] == ALL_ONES[BYTE_W-1:3] || !rstN);
  end
endmodule

// File: rtl/addr_gen.sv
module addr_gen
  import addrgen_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2 * BYTE_W,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        lowSel,
  input  logic [2:0]        highSel,
  input  logic              incDir,
  input  logic              wbPc,
  input  logic              wbSp,
  input  logic              pcLoad,
  input  logic [ADDR_W-1:0] pcLoadVal,
  input  logic              spLoad,
  input  logic [BYTE_W-1:0] spLoadVal,
  input  logic [BYTE_W-1:0] dpl,
  input  logic [BYTE_W-1:0] dph,
  input  logic [BYTE_W-1:0] tByte,
  input  logic [1:0]        vecSel,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] incBus,
  output logic [ADDR_W-1:0] pcOut,
  output logic [BYTE_W-1:0] spOut,
  output logic [BYTE_W-1:0] vecLow
);
  addrStrobes_t st;

  addr_ctrl ctrl_i (
    .lowSel (lowSel),
    .highSel(highSel),
    .incDir (incDir),
    .wbPc   (wbPc),
    .wbSp   (wbSp),
    .pcLoad (pcLoad),
    .spLoad (spLoad),
    .st     (st)
  );

  addr_path #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) path_i (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .pcLoadVal(pcLoadVal),
    .spLoadVal(spLoadVal),
    .dpl      (dpl),
    .dph      (dph),
    .tByte    (tByte),
    .vecSel   (vecSel),
    .addr     (addr),
    .incBus   (incBus),
    .pcOut    (pcOut),
    .spOut    (spOut),
    .vecLow   (vecLow)
  );
endmodule

// File: tb/addr_gen_tb.sv
module addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  lowSel = '0;
  logic [2:0]  highSel = '0;
  logic        incDir = 1'b0;
  logic        wbPc = 1'b0, wbSp = 1'b0, pcLoad = 1'b0, spLoad = 1'b0;
  logic [15:0] pcLoadVal = '0;
  logic [7:0]  spLoadVal = '0;
  logic [7:0]  dpl = 8'hCD, dph = 8'hAB, tByte = 8'h5E;
  logic [1:0]  vecSel = '0;
  logic [15:0] addr, incBus, pcOut;
  logic [7:0]  spOut, vecLow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addr_gen dut_i (
    .clk(clk), .rstN(rstN), .lowSel(lowSel), .highSel(highSel),
    .incDir(incDir), .wbPc(wbPc), .wbSp(wbSp), .pcLoad(pcLoad),
    .pcLoadVal(pcLoadVal), .spLoad(spLoad), .spLoadVal(spLoadVal),
    .dpl(dpl), .dph(dph), .tByte(tByte), .vecSel(vecSel),
    .addr(addr), .incBus(incBus), .pcOut(pcOut), .spOut(spOut),
    .vecLow(vecLow)
  );

  // {lowSel, highSel, incDir, expected addr, expected incBus}
  // with PC=0x12FF, SP=0x80, DP=0xABCD, T=0x5E
  localparam logic [37:0] TBL [10] = '{
    {2'd0, 3'd0, 1'b0, 16'h12FF, 16'h1300},
    {2'd0, 3'd0, 1'b1, 16'h12FF, 16'h12FE},
    {2'd1, 3'd1, 1'b0, 16'hABCD, 16'hABCE},
    {2'd2, 3'd3, 1'b1, 16'h0180, 16'h017F},
    {2'd3, 3'd1, 1'b0, 16'hAB5E, 16'hAB5F},
    {2'd3, 3'd2, 1'b0, 16'h005E, 16'h005F},
    {2'd1, 3'd4, 1'b0, 16'hFFCD, 16'hFFCE},
    {2'd0, 3'd5, 1'b0, 16'h00FF, 16'h0100},
    {2'd2, 3'd6, 1'b1, 16'h0080, 16'h007F},
    {2'd1, 3'd7, 1'b1, 16'h00CD, 16'h00CC}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic clearStrobes;
    wbPc = 0; wbSp = 0; pcLoad = 0; spLoad = 0;
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    tick(); tick();
    // R1: reset values, checked during and after reset
    chk("R1 sp in reset", {24'd0, spOut}, 32'hFF);
    rstN = 1'b1;
    tick();
    chk("R1 pc after reset", {16'd0, pcOut}, 32'h0000);
    chk("R1 sp after reset", {24'd0, spOut}, 32'hFF);
    chk("R1 addr from pc", {16'd0, addr}, 32'h0000);

    // setup: PC=0x12FF, SP=0x80
    pcLoad = 1; pcLoadVal = 16'h12FF; spLoad = 1; spLoadVal = 8'h80;
    tick(); clearStrobes();
    chk("R7 pc load", {16'd0, pcOut}, 32'h12FF);
    chk("R7 sp load", {24'd0, spOut}, 32'h80);

    // R2 R3 R4: table walk
    for (int i = 0; i < 10; i++) begin
      lowSel  = TBL[i][37:36];
      highSel = TBL[i][35:33];
      incDir  = TBL[i][32];
      #1;
      chk("R2/R3 addr mux", {16'd0, addr}, {16'd0, TBL[i][31:16]});
      chk("R4 incBus", {16'd0, incBus}, {16'd0, TBL[i][15:0]});
      tick();
    end
    // R9: selects changed, no strobes, registers unchanged
    chk("R9 pc hold", {16'd0, pcOut}, 32'h12FF);
    chk("R9 sp hold", {24'd0, spOut}, 32'h80);

    // R8: vector constants
    for (int v = 0; v < 4; v++) begin
      vecSel = 2'(v);
      #1;
      chk("R8 vecLow", {24'd0, vecLow}, (v == 0) ? 32'hFA : (v == 1) ? 32'hFC : (v == 2) ? 32'hFE : 32'hFF);
    end

    // R5: PC write-back with wrap
    pcLoad = 1; pcLoadVal = 16'hFFFF; tick(); clearStrobes();
    lowSel = 2'd0; highSel = 3'd0; incDir = 0; wbPc = 1;
    tick(); clearStrobes();
    chk("R5 pc wrap", {16'd0, pcOut}, 32'h0000);
    incDir = 1; wbPc = 1; tick(); clearStrobes();
    chk("R5 pc decrement wrap", {16'd0, pcOut}, 32'hFFFF);

    // R7: load wins over write-back
    pcLoad = 1; pcLoadVal = 16'h1234; wbPc = 1; incDir = 0;
    spLoad = 1; spLoadVal = 8'h42; wbSp = 1;
    tick(); clearStrobes();
    chk("R7 pc precedence", {16'd0, pcOut}, 32'h1234);
    chk("R7 sp precedence", {24'd0, spOut}, 32'h42);

    // R6: SP wraps inside the stack page
    spLoad = 1; spLoadVal = 8'h00; tick(); clearStrobes();
    lowSel = 2'd2; highSel = 3'd3; incDir = 1; wbSp = 1;
    #1;
    chk("R6 push addr before decrement", {16'd0, addr}, 32'h0100);
    tick(); clearStrobes();
    chk("R6 sp wrap down", {24'd0, spOut}, 32'hFF);
    incDir = 0; wbSp = 1; tick(); clearStrobes();
    chk("R6 sp wrap up", {24'd0, spOut}, 32'h00);

    // R6: push then pull sequence
    spLoad = 1; spLoadVal = 8'h80; tick(); clearStrobes();
    incDir = 1; wbSp = 1;
    #1;
    chk("R6 push addr", {16'd0, addr}, 32'h0180);
    tick(); clearStrobes();
    chk("R6 sp after push", {24'd0, spOut}, 32'h7F);
    incDir = 0; wbSp = 1; tick(); clearStrobes();
    #1;
    chk("R6 pull read addr", {16'd0, addr}, 32'h0180);
    chk("R9 pc untouched by stack ops", {16'd0, pcOut}, 32'h1234);

    tick();
    finishRun();
  end
endmodule